// File: doc/BRIEF.md
# Real-Time Clock Register Port

This block is the register front end of a real-time clock on a byte-wide bus. Software writes a register number to the index port. Each read of the data port then returns the selected time field or control value. The block keeps time and date in plain binary. The starting values come from parameters, and the count moves forward one second on each strobe of a 1 Hz enable input.

A free-running divider produces a periodic event at a rate of 1024 Hz. It is given as a number of core clock cycles. When the event fires and no clock interrupt is outstanding, the block raises an interrupt request and sets the top bit of a status byte. Both stay set until an acknowledge strobe arrives.

Control register A returns a fixed rate code together with an update-in-progress flag, and the flag flips on every read of that register. Register B reads back a fixed mode word and register C reads back as zero. The following raise a one-cycle error pulse, because this block does not provide them:
- writes to the data port;
- register D;
- alarm registers and any other index.

Top module: `rtc_regport`

## Requirements
- R1: A write with `sel_i`=0 loads the index. A read with `sel_i`=1 places the indexed value on `rdata_o` in the following cycle, and `rdata_o` holds between reads. The indices are: 0 seconds, 2 minutes, 4 hours, 6 weekday, 7 day of month, 8 month, 9 year, 0x0A A, 0x0B B, 0x0C C, 0x0D D.
- R2: Reading register A returns {uip, 7'h26}. Each such read inverts uip, and uip is 1 after reset.
- R3: Reading register B returns 0x46, and reading register C returns 0x00.
- R4: `err_o` pulses for one cycle after any of these: a read of register D, a read of an unlisted index, or a write to the data port. Such a read returns 0x00, and such a write leaves the time and the index unchanged.
- R5: Time fields read in binary. Month is 1..12, weekday is 0..6 with 0 for Sunday, and the year reads as the years since 1900 minus 52. After reset the fields hold the parameter values, which default to 2006-01-01 00:00:00, a Sunday.
- R6: Each cycle with `tick_1hz_i` high advances the seconds. Rollover carries into minutes, hours, weekday, day of month, month and year.
- R7: Month lengths are 31/30/28. February has 29 days in a leap year: a year divisible by 4, except 1900 and 2100.
- R8: A periodic event fires every `PER_DIV` cycles after reset. If no interrupt is pending, it sets `irq_o` and `misc_o[7]`, and both stay set until they are acknowledged.
- R9: `irq_ack_i` clears `irq_o` and `misc_o[7]` in the next cycle. If an event coincides with the acknowledge, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_1hz_i | input | 1 | one-second advance enable |
| wr_i | input | 1 | bus write strobe |
| rd_i | input | 1 | bus read strobe |
| sel_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data |
| err_o | output | 1 | one-cycle error pulse |
| irq_ack_i | input | 1 | interrupt acknowledge |
| irq_o | output | 1 | periodic interrupt request |
| misc_o | output | 8 | status byte, bit 7 = clock interrupt pending |

## Verification
The bench sets `PER_DIV` to 8 so that many periodic events fit in a short run, including events that collide with acknowledges. It starts the clock at 2100-02-28 23:59:50. About ten one-second ticks then carry through minutes, hours and weekday into a century year that is not a leap year. Because February ends on day 28, the test exercises March 1 as the next date.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] IX_SEC  = 8'h00;
  localparam logic [7:0] IX_MIN  = 8'h02;
  localparam logic [7:0] IX_HOUR = 8'h04;
  localparam logic [7:0] IX_WDAY = 8'h06;
  localparam logic [7:0] IX_MDAY = 8'h07;
  localparam logic [7:0] IX_MON  = 8'h08;
  localparam logic [7:0] IX_YEAR = 8'h09;
  localparam logic [7:0] IX_CA   = 8'h0A;
  localparam logic [7:0] IX_CB   = 8'h0B;
  localparam logic [7:0] IX_CC   = 8'h0C;
  localparam logic [7:0] A_CODE  = 8'h26;
  localparam logic [7:0] B_CODE  = 8'h46;
  localparam logic [7:0] YEAR_OFS = 8'd52;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year; // years since 1900
  } rtc_time_t;

  function automatic logic is_leap(input logic [7:0] y);
    return (y[1:0] == 2'b00) && (y != 8'd0) && (y != 8'd200);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'd2:                    return is_leap(y) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
#(
  parameter rtc_time_t INIT = '0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  output rtc_time_t time_o
);
  rtc_time_t t_q, t_d;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    t_d    = t_q;
    c_min  = t_q.sec  == 8'd59;
    c_hour = c_min  && (t_q.min  == 8'd59);
    c_day  = c_hour && (t_q.hour == 8'd23);
    c_mon  = c_day  && (t_q.mday == month_days(t_q.mon, t_q.year));
    c_year = c_mon  && (t_q.mon  == 8'd12);
    if (tick_i) begin
      t_d.sec = c_min ? 8'd0 : t_q.sec + 8'd1;
      if (c_min)  t_d.min  = (t_q.min == 8'd59) ? 8'd0 : t_q.min + 8'd1;
      if (c_hour) t_d.hour = (t_q.hour == 8'd23) ? 8'd0 : t_q.hour + 8'd1;
      if (c_day) begin
        t_d.wday = (t_q.wday == 8'd6) ? 8'd0 : t_q.wday + 8'd1;
        t_d.mday = c_mon ? 8'd1 : t_q.mday + 8'd1;
      end
      if (c_mon)  t_d.mon  = c_year ? 8'd1 : t_q.mon + 8'd1;
      if (c_year) t_d.year = t_q.year + 8'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) t_q <= INIT;
    else         t_q <= t_d;

  assign time_o = t_q;
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int unsigned PER_DIV = 48828,
  localparam int unsigned CW = (PER_DIV > 1) ? $clog2(PER_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  logic [CW-1:0] cnt_q;
  logic          fire;

  assign fire = cnt_q == CW'(PER_DIV - 1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= fire ? '0 : cnt_q + 1'b1;
      if (ack_i)     pend_o <= 1'b0;
      else if (fire) pend_o <= 1'b1;
    end
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_pkg::*;
#(
  parameter int unsigned PER_DIV   = 48828,
  parameter logic [7:0]  INIT_SEC  = 8'd0,
  parameter logic [7:0]  INIT_MIN  = 8'd0,
  parameter logic [7:0]  INIT_HOUR = 8'd0,
  parameter logic [7:0]  INIT_WDAY = 8'd0,
  parameter logic [7:0]  INIT_MDAY = 8'd1,
  parameter logic [7:0]  INIT_MON  = 8'd1,
  parameter logic [7:0]  INIT_YEAR = 8'd106
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_1hz_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       err_o,
  input  logic       irq_ack_i,
  output logic       irq_o,
  output logic [7:0] misc_o
);
  localparam rtc_time_t INIT = '{sec: INIT_SEC, min: INIT_MIN, hour: INIT_HOUR,
                                 wday: INIT_WDAY, mday: INIT_MDAY, mon: INIT_MON,
                                 year: INIT_YEAR};

  rtc_time_t  now;
  logic [7:0] idx_q;
  logic       uip_q;
  logic       pend;
  logic       rd_dat, rd_bad;
  logic [7:0] rd_val;

  rtc_timekeep #(.INIT(INIT)) u_time (
    .clk_i, .rst_ni, .tick_i(tick_1hz_i), .time_o(now)
  );

  rtc_periodic #(.PER_DIV(PER_DIV)) u_per (
    .clk_i, .rst_ni, .ack_i(irq_ack_i), .pend_o(pend)
  );

  assign rd_dat = rd_i && sel_i;

  always_comb begin
    rd_bad = 1'b0;
    case (idx_q)
      IX_SEC:  rd_val = now.sec;
      IX_MIN:  rd_val = now.min;
      IX_HOUR: rd_val = now.hour;
      IX_WDAY: rd_val = now.wday;
      IX_MDAY: rd_val = now.mday;
      IX_MON:  rd_val = now.mon;
      IX_YEAR: rd_val = now.year - YEAR_OFS;
      IX_CA:   rd_val = {uip_q, A_CODE[6:0]};
      IX_CB:   rd_val = B_CODE;
      IX_CC:   rd_val = 8'h00;
      default: begin
        rd_val = 8'h00;
        rd_bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      idx_q   <= '0;
      uip_q   <= 1'b1;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= (wr_i && sel_i) || (rd_dat && rd_bad);
      if (wr_i && !sel_i) idx_q <= wdata_i;
      if (rd_dat) begin
        rdata_o <= rd_val;
        if (idx_q == IX_CA) uip_q <= ~uip_q;
      end
    end

  assign irq_o  = pend;
  assign misc_o = {pend, 7'b0};
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic       sel_i,
  input logic [7:0] idx_q,
  input logic [7:0] rdata_o,
  input logic       err_o,
  input logic       irq_ack_i,
  input logic       irq_o,
  input logic [7:0] misc_o
);
  logic rd_a;
  logic exp_uip;
  assign rd_a = rd_i && sel_i && (idx_q == IX_CA);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   exp_uip <= 1'b1;
    else if (rd_a) exp_uip <= ~exp_uip;

  assert_a_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a |=> (rdata_o == {$past(exp_uip), 7'h26}));

  assert_b_const_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i && idx_q == IX_CB) |=> (rdata_o == 8'h46));

  assert_c_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i && idx_q == IX_CC) |=> (rdata_o == 8'h00));

  assert_wr_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> err_o);

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && sel_i) |=> $stable(rdata_o));

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> (irq_o && misc_o[7]));

  assert_ack_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> (!irq_o && !misc_o[7]));
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk_i, .rst_ni, .wr_i, .rd_i, .sel_i, .idx_q, .rdata_o, .err_o,
  .irq_ack_i, .irq_o, .misc_o
);

// File: tb/test_rtc_regport.sv
module test_rtc_regport;
  localparam int CLK_PERIOD = 10;
  localparam int PDIV = 8;

  logic clk = 0, rst_n = 0;
  logic tick = 0, wr = 0, rd = 0, sel = 0, ack = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata, misc;
  logic err, irq;

  rtc_regport #(.PER_DIV(PDIV), .INIT_SEC(8'd50), .INIT_MIN(8'd59), .INIT_HOUR(8'd23),
    .INIT_WDAY(8'd0), .INIT_MDAY(8'd28), .INIT_MON(8'd2), .INIT_YEAR(8'd200)) i_rtc_regport (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .wr_i(wr), .rd_i(rd), .sel_i(sel),
    .wdata_i(wd), .rdata_o(rdata), .err_o(err), .irq_ack_i(ack), .irq_o(irq), .misc_o(misc));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int m_idx, m_uip, m_rd, m_err, m_pend, m_pc;
  int s, mi, h, wdy, md, mo, yr;

  function automatic int dim(int m, int y);
    int yy = 1900 + y;
    if (m == 2) return ((yy % 4 == 0) && (yy % 100 != 0 || yy % 400 == 0)) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_uip = 1; m_rd = 0; m_err = 0; m_pend = 0; m_pc = 0;
      s = 50; mi = 59; h = 23; wdy = 0; md = 28; mo = 2; yr = 200;
    end else begin
      m_err = 0;
      if (wr && sel) m_err = 1;
      if (rd && sel) begin
        case (m_idx)
          0: m_rd = s;  2: m_rd = mi; 4: m_rd = h; 6: m_rd = wdy;
          7: m_rd = md; 8: m_rd = mo; 9: m_rd = (yr - 52) & 255;
          10: begin m_rd = m_uip * 128 + 38; m_uip = 1 - m_uip; end
          11: m_rd = 70;
          12: m_rd = 0;
          default: begin m_rd = 0; m_err = 1; end
        endcase
      end
      if (wr && !sel) m_idx = wd;
      if (ack) m_pend = 0;
      else if (m_pc == PDIV - 1) m_pend = 1;
      m_pc = (m_pc + 1) % PDIV;
      if (tick) begin
        s++;
        if (s == 60) begin s = 0; mi++; end
        if (mi == 60) begin mi = 0; h++; end
        if (h == 24) begin
          h = 0; wdy = (wdy + 1) % 7; md++;
          if (md > dim(mo, yr)) begin md = 1; mo++; end
          if (mo == 13) begin mo = 1; yr++; end
        end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (rdata !== m_rd[7:0]) begin errors++; $display("FAIL R1 rdata got %h exp %h", rdata, m_rd[7:0]); end
    checks++;
    if (err !== m_err[0]) begin errors++; $display("FAIL R4 err got %b exp %b", err, m_err[0]); end
    checks++;
    if (irq !== m_pend[0] || misc !== {m_pend[0], 7'b0}) begin
      errors++; $display("FAIL R8 irq/misc got %b/%h exp %b", irq, misc, m_pend[0]);
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin errors++; $display("FAIL %s got %h exp %h", tag, got, exp); end
  endtask

  task automatic set_idx(logic [7:0] v);
    @(negedge clk); wr = 1; sel = 0; wd = v;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_dat(output logic [7:0] v);
    @(negedge clk); rd = 1; sel = 1;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic rd_at(logic [7:0] ix, output logic [7:0] v);
    set_idx(ix); rd_dat(v);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R8 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    // R2: uip starts at 1 and toggles
    rd_at(8'h0A, v); chk("R2 first A", v, 8'hA6);
    rd_dat(v);       chk("R2 second A", v, 8'h26);
    rd_dat(v);       chk("R2 third A", v, 8'hA6);
    rd_at(8'h0B, v); chk("R3 B", v, 8'h46);
    rd_at(8'h0C, v); chk("R3 C", v, 8'h00);
    // R4: D, alarm index, data write
    set_idx(8'h0D);
    @(negedge clk); rd = 1; sel = 1;
    @(negedge clk); rd = 0; chk("R4 err on D", {7'b0, err}, 8'h01);
    set_idx(8'h01);
    @(negedge clk); rd = 1; sel = 1;
    @(negedge clk); rd = 0; chk("R4 err on alarm", {7'b0, err}, 8'h01);
    set_idx(8'h09);
    @(negedge clk); wr = 1; sel = 1; wd = 8'h00;
    @(negedge clk); wr = 0; chk("R4 err on data write", {7'b0, err}, 8'h01);
    rd_dat(v); chk("R4 write ignored, year", v, 8'd148);
    // R5 fields
    rd_at(8'h00, v); chk("R5 sec", v, 8'd50);
    rd_at(8'h08, v); chk("R5 month", v, 8'd2);
    rd_at(8'h07, v); chk("R5 mday", v, 8'd28);
    // R6/R7: carry to March 1 in a non-leap century year
    repeat (10) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
    rd_at(8'h00, v); chk("R6 sec wrap", v, 8'd0);
    rd_at(8'h02, v); chk("R6 min wrap", v, 8'd0);
    rd_at(8'h04, v); chk("R6 hour wrap", v, 8'd0);
    rd_at(8'h06, v); chk("R6 weekday", v, 8'd1);
    rd_at(8'h07, v); chk("R7 mday", v, 8'd1);
    rd_at(8'h08, v); chk("R7 month", v, 8'd3);
    // R8/R9: interrupt and acknowledge
    @(negedge clk); wait (irq === 1'b1);
    @(negedge clk); chk("R8 misc bit7", misc, 8'h80);
    ack = 1; @(negedge clk); ack = 0;
    chk("R9 ack clears", {7'b0, irq}, 8'h00);
    repeat (3 * PDIV) begin @(negedge clk); ack = 1; end
    @(negedge clk); ack = 0;
    chk("R9 ack held", {7'b0, irq}, 8'h00);
    repeat (PDIV + 2) @(negedge clk);
    chk("R8 refire", {7'b0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule